// File: doc/BRIEF.md
# Direction-Flag Circular FIFO

This block is a single-clock first-in/first-out buffer that sits between a producer and a consumer running on the same clock. Entries are held in a dual-port RAM with one write port and one synchronous read port. The write location and the read location each come from their own address counter. The counters wrap, so the storage forms a ring of 2^ADDR_W entries, which is 256 entries at the default width of 8 address bits.

When the two counters hold the same value, the ring is either completely full or completely empty. The block tells these two cases apart with a one-bit direction register, not with a widened pointer or an occupancy count. A write that is accepted without an accepted read sets the direction to "filling". A read that is accepted without an accepted write sets it to "emptying". When both are accepted in the same cycle, or neither is, the direction does not change. Full means the counters are equal while filling. Empty means the counters are equal while emptying.

Requests that cannot be served are dropped: a write while full, or a read while empty. Read data is registered and appears on the cycle after an accepted read.

Top module: `dir_flag_fifo`

## Requirements
- R1: During reset and in the first cycle after it, `empty` is 1 and `full` is 0. `rd_data` resets to 0.
- R2: Data leaves the buffer in exactly the order in which it was accepted.
- R3: After an accepted read, the entry appears on `rd_data` at the next rising edge. `rd_data` keeps its value in any cycle with no accepted read.
- R4: After 2^ADDR_W accepted writes with no reads, `full` is 1 and `empty` is 0.
- R5: A write request while `full` is 1 and no read is requested is dropped. `full` stays 1, and the stored contents and their order do not change.
- R6: A read request while `empty` is 1 and no write is requested is dropped. `empty` stays 1, `rd_data` keeps its value, and the read address does not advance.
- R7: When a write and a read are both accepted in the same cycle, the occupancy does not change, so `full` and `empty` keep their values.
- R8: A simultaneous write and read while `full` is 1 performs only the read, so `full` drops. A simultaneous write and read while `empty` is 1 performs only the write, so `empty` drops and `rd_data` keeps its value.
- R9: Both address counters wrap from 2^ADDR_W-1 to 0. After the ring has been filled and drained more than once, the order and the flags stay correct.
- R10: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Entry to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered head entry from the last accepted read |
| full | output | 1 | Ring is full |
| empty | output | 1 | Ring is empty |

## Verification
The write and the read can fall in the same cycle. How the block handles this decides both the direction register and the flags. The bench first keeps a write and a read request active together over several cycles at a middle occupancy. It then issues the same pair exactly when the ring is empty and exactly when it is full. A bench model accepts each request only if the requirements allow it and predicts the next `rd_data`, `full` and `empty`. In the full case only the head entry may come out, and in the empty case only the new entry may go in.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

    typedef enum logic {
        DIR_EMPTYING = 1'b0,
        DIR_FILLING  = 1'b1
    } dir_e;

    typedef struct packed {
        logic put;
        logic take;
    } xfer_t;

    function automatic dir_e dir_next(input dir_e cur, input xfer_t x);
        dir_e nxt;
        nxt = cur;
        if (x.put && !x.take)
            nxt = DIR_FILLING;
        else if (x.take && !x.put)
            nxt = DIR_EMPTYING;
        return nxt;
    endfunction

endpackage

// File: rtl/dfifo_addr_ctr.sv
module dfifo_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/dfifo_dir_ctl.sv
module dfifo_dir_ctl
    import dfifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xfer,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              full,
    output logic              empty
);
    dir_e dir_q;
    logic same;

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= DIR_EMPTYING;
        else
            dir_q <= dir_next(dir_q, xfer);
    end

    always_comb begin
        same  = (wr_addr == rd_addr);
        full  = same && (dir_q == DIR_FILLING);
        empty = same && (dir_q == DIR_EMPTYING);
    end
endmodule

// File: rtl/dfifo_ram.sv
module dfifo_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= cells[raddr];
    end
endmodule

// File: rtl/dir_flag_fifo.sv
module dir_flag_fifo
    import dfifo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    xfer_t             xfer;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    always_comb begin
        xfer.put  = wr_en && !full;
        xfer.take = rd_en && !empty;
    end

    dfifo_addr_ctr #(.ADDR_W(ADDR_W)) u_wr_ctr (
        .clk (clk),
        .rst (rst),
        .step(xfer.put),
        .addr(wr_addr)
    );

    dfifo_addr_ctr #(.ADDR_W(ADDR_W)) u_rd_ctr (
        .clk (clk),
        .rst (rst),
        .step(xfer.take),
        .addr(rd_addr)
    );

    dfifo_dir_ctl #(.ADDR_W(ADDR_W)) u_dir (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .full   (full),
        .empty  (empty)
    );

    dfifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk  (clk),
        .rst  (rst),
        .we   (xfer.put),
        .waddr(wr_addr),
        .wdata(wr_data),
        .re   (xfer.take),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/dir_flag_fifo_chk.sv
module dir_flag_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              empty
);
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (empty && !full));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));

    p_both_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_en && rd_en) |=> ($stable(full) && $stable(empty)));

    p_full_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> !full);

    p_empty_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en && rd_en) |=> (!empty && $stable(rd_data)));
endmodule

bind dir_flag_fifo dir_flag_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .full   (full),
    .empty  (empty)
);

// File: tb/sim_dir_flag_fifo.sv
module sim_dir_flag_fifo;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          full;
    logic          empty;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_rd = '0;

    always #2 clk = ~clk;

    dir_flag_fifo #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty)
    );

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, exp_rd);
        end
        check_bit(tag, "full", full, model_q.size() == DEPTH);
        check_bit(tag, "empty", empty, model_q.size() == 0);
    endtask

    // one clock cycle: drive at the falling edge, sample 1 ns after the rising edge
    task automatic step(input string tag, input logic w, input logic [DW-1:0] d, input logic r);
        bit put;
        bit take;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r;
        put  = w && (model_q.size() < DEPTH);
        take = r && (model_q.size() > 0);
        @(posedge clk);
        #1;
        if (take) exp_rd = model_q.pop_front();
        if (put) model_q.push_back(d);
        wr_en = 1'b0; rd_en = 1'b0;
        check_outputs(tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1", "empty in reset", empty, 1'b1);
        check_bit("R1", "full in reset", full, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_outputs("R1");
    endtask

    task automatic t_fill_overflow;
        for (int i = 0; i < DEPTH; i++) step("R4", 1'b1, DW'(i * 7 + 3), 1'b0);
        check_bit("R4", "full after fill", full, 1'b1);
        step("R5", 1'b1, 8'hEE, 1'b0);
        step("R5", 1'b1, 8'hEF, 1'b0);
    endtask

    task automatic t_drain_underflow;
        for (int i = 0; i < DEPTH; i++) step("R2", 1'b0, '0, 1'b1);
        check_bit("R9", "empty after drain", empty, 1'b1);
        step("R6", 1'b0, '0, 1'b1);
        step("R6", 1'b0, '0, 1'b1);
        step("R6", 1'b1, 8'h5A, 1'b0);
        step("R6", 1'b0, '0, 1'b1);
    endtask

    task automatic t_read_latency;
        step("R3", 1'b1, 8'h11, 1'b0);
        step("R3", 1'b1, 8'h22, 1'b0);
        step("R3", 1'b0, '0, 1'b1);
        step("R3", 1'b0, '0, 1'b0);
        step("R3", 1'b0, '0, 1'b0);
        step("R3", 1'b0, '0, 1'b1);
    endtask

    task automatic t_concurrent_mid;
        for (int i = 0; i < 3; i++) step("R7", 1'b1, DW'(8'h40 + i), 1'b0);
        for (int i = 0; i < 6; i++) step("R7", 1'b1, DW'(8'h80 + i), 1'b1);
        for (int i = 0; i < 3; i++) step("R7", 1'b0, '0, 1'b1);
    endtask

    task automatic t_concurrent_edges;
        step("R8", 1'b1, 8'hC3, 1'b1);
        step("R8", 1'b0, '0, 1'b1);
        for (int i = 0; i < DEPTH; i++) step("R9", 1'b1, DW'(255 - i), 1'b0);
        step("R8", 1'b1, 8'h77, 1'b1);
        step("R8", 1'b1, 8'h78, 1'b0);
        check_bit("R8", "full refilled", full, 1'b1);
        for (int i = 0; i < DEPTH; i++) step("R9", 1'b0, '0, 1'b1);
        check_bit("R9", "empty after wrap", empty, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fill_overflow();
        t_drain_underflow();
        t_read_latency();
        t_concurrent_mid();
        t_concurrent_edges();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule